// File: doc/BRIEF.md
# Pin Bank Register File

This block holds the control state for a bank of general-purpose pins grouped into four ports of eight pins each. Software reaches it over a simple 32-bit memory-mapped bus. Each port has four registers:

- a mode register, which selects plain pin use (1) or alternate-function use (0);
- a drive-enable register;
- an output-level register;
- a read-only register that returns the pad levels after a two-flop synchronizer.

The block drives the pad output level and pad output-enable vectors straight from its registers.

The mode, drive-enable and output-level registers also appear at a second, masked address. A single write there changes only the pins that the write selects. Software can therefore flip one pin without a read-modify-write, and without racing other agents that update neighbouring pins.

Top module: `pin_bank_regs`

## Requirements
- R1: After reset every register reads zero and both `pad_out` and `pad_oe` are all zero.
- R2: Register word addresses are the kind base plus 4 times the port index. The kind bases are 0x00 for mode, 0x10 for drive enable, 0x20 for output level and 0x30 for input level.
- R3: A plain write replaces all 8 bits of the addressed register with `bus_wdata[7:0]`.
- R4: A write at the plain address plus `ALIAS_OFS` (default 0x80) is a masked write. For each n, it sets register bit n to `bus_wdata[n]` only when `bus_wdata[8+n]` is 1, and leaves bit n unchanged otherwise.
- R5: A read of a masked address returns the plain register value in bits 7:0 and zero in bits 31:8. Every read returns zero in bits 31:8.
- R6: Writes to the input register, at either its plain or its masked address, change no register and no pad output.
- R7: A pad level change becomes visible in an input-register read whose data is captured on the third rising clock edge after the change. Reads captured on the first or second edge still return the old level.
- R8: `pad_oe` bit is 1 only where both the mode bit and the drive-enable bit are 1. `pad_out` equals the output-level register.
- R9: Read data is registered: it appears one cycle after a read request and holds until the next read. Addresses outside the map read zero, and writes to them are ignored. An address is outside the map when any bit other than bits 5:0 and the `ALIAS_OFS` bit is set. The masked input address (0xB0 + 4·port) also reads zero.
- R10: Pad index p·8+n belongs to port p, pin n. Port is bits 4:3 of the pad index and pin is bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |

## Verification
A wrong bit in the mode, drive-enable or output-level state shows on `pad_out` or `pad_oe` right after the clock edge that stored it. The same wrong bit is also returned by the next read of either the plain or the masked address. A mis-merged masked write therefore shows up in the following cycle as a pin that moved without being selected, or as a selected pin that kept its old value. The input path is checked edge by edge, so a missing or extra synchronizer stage moves the first new value by one read and is caught.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
   typedef enum logic [1:0] {
      K_MODE  = 2'd0,
      K_DRIVE = 2'd1,
      K_LEVEL = 2'd2,
      K_SENSE = 2'd3
   } reg_kind_e;

   typedef struct packed {
      logic      hit;
      logic      masked;
      reg_kind_e kind;
      logic [1:0] port;
   } dec_t;
endpackage

// File: rtl/pbr_sync.sv
module pbr_sync #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         q      <= '0;
      end else begin
         meta_q <= d;
         q      <= meta_q;
      end
   end
endmodule

// File: rtl/pbr_decode.sv
module pbr_decode
   import pbr_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int ALIAS_OFS = 128,
   parameter int NUM_PORTS = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   localparam logic [ADDR_W-1:0] KEEP_BITS = ADDR_W'(ALIAS_OFS) | ADDR_W'(63);

   always_comb begin
      dec.masked = (addr & ADDR_W'(ALIAS_OFS)) != '0;
      dec.kind   = reg_kind_e'(addr[5:4]);
      dec.port   = addr[3:2];
      dec.hit    = ((addr & ~KEEP_BITS) == '0) && (int'(addr[3:2]) < NUM_PORTS);
      if (dec.masked && dec.kind == K_SENSE) dec.hit = 1'b0;
   end
endmodule

// File: rtl/pbr_port_reg.sv
module pbr_port_reg #(
   parameter int PINS   = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        wr,
   input  logic              masked,
   input  logic [DATA_W-1:0] wdata,
   output logic [PINS-1:0]   mode_q,
   output logic [PINS-1:0]   drive_q,
   output logic [PINS-1:0]   level_q
);
   logic [PINS-1:0] q [3];
   logic [PINS-1:0] sel_bits;
   logic [PINS-1:0] new_bits;

   assign sel_bits = wdata[2*PINS-1:PINS];
   assign new_bits = wdata[PINS-1:0];

   for (genvar k = 0; k < 3; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[k] <= '0;
         end else if (wr[k]) begin
            if (masked) q[k] <= (q[k] & ~sel_bits) | (new_bits & sel_bits);
            else        q[k] <= new_bits;
         end
      end

      AST_PLAIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         wr[k] && !masked |=> q[k] == $past(wdata[PINS-1:0])); // R3
      AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         wr[k] && masked |=> ((q[k] ^ $past(q[k])) & ~$past(wdata[2*PINS-1:PINS])) == '0); // R4
      AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
         wr[k] && masked |=> ((q[k] ^ $past(wdata[PINS-1:0])) & $past(wdata[2*PINS-1:PINS])) == '0); // R4
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !wr[k] |=> $stable(q[k])); // R6
   end

   assign mode_q  = q[0];
   assign drive_q = q[1];
   assign level_q = q[2];
endmodule

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
   import pbr_pkg::*;
#(
   parameter int PINS      = 8,
   parameter int NUM_PORTS = 4,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int ALIAS_OFS = 128
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_sel,
   input  logic                      bus_we,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [DATA_W-1:0]         bus_rdata,
   input  logic [PINS*NUM_PORTS-1:0] pad_in,
   output logic [PINS*NUM_PORTS-1:0] pad_out,
   output logic [PINS*NUM_PORTS-1:0] pad_oe
);
   localparam int NPAD = PINS * NUM_PORTS;

   if (PINS > 8 || 2 * PINS > DATA_W) begin : g_bad_pins
      $error("PINS must be at most 8 and fit twice into DATA_W");
   end
   if (NUM_PORTS < 1 || NUM_PORTS > 4) begin : g_bad_ports
      $error("NUM_PORTS must be 1 to 4");
   end
   if (ALIAS_OFS < 64 || (ALIAS_OFS & (ALIAS_OFS - 1)) != 0 || ALIAS_OFS >= (1 << ADDR_W)) begin : g_bad_alias
      $error("ALIAS_OFS must be a power of two from 64 inside the address space");
   end

   dec_t            dec;
   logic [NPAD-1:0] sense_q;
   logic [PINS-1:0] mode_q  [NUM_PORTS];
   logic [PINS-1:0] drive_q [NUM_PORTS];
   logic [PINS-1:0] level_q [NUM_PORTS];
   logic [PINS-1:0] rd_byte;
   logic            wr_go;

   pbr_decode #(.ADDR_W(ADDR_W), .ALIAS_OFS(ALIAS_OFS), .NUM_PORTS(NUM_PORTS)) u_decode (
      .addr (bus_addr),
      .dec  (dec)
   );

   pbr_sync #(.W(NPAD)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sense_q)
   );

   assign wr_go = bus_sel && bus_we && dec.hit;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [2:0] wr;
      logic       here;
      assign here  = wr_go && (int'(dec.port) == p);
      assign wr[0] = here && dec.kind == K_MODE;
      assign wr[1] = here && dec.kind == K_DRIVE;
      assign wr[2] = here && dec.kind == K_LEVEL;

      pbr_port_reg #(.PINS(PINS), .DATA_W(DATA_W)) u_port (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (wr),
         .masked  (dec.masked),
         .wdata   (bus_wdata),
         .mode_q  (mode_q[p]),
         .drive_q (drive_q[p]),
         .level_q (level_q[p])
      );

      assign pad_out[p*PINS +: PINS] = level_q[p];
      assign pad_oe[p*PINS +: PINS]  = mode_q[p] & drive_q[p];
   end

   always_comb begin
      rd_byte = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (dec.hit && int'(dec.port) == p) begin
            unique case (dec.kind)
               K_MODE:  rd_byte = mode_q[p];
               K_DRIVE: rd_byte = drive_q[p];
               K_LEVEL: rd_byte = level_q[p];
               K_SENSE: rd_byte = sense_q[p*PINS +: PINS];
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                bus_rdata <= '0;
      else if (bus_sel && !bus_we) bus_rdata <= {{(DATA_W-PINS){1'b0}}, rd_byte};
   end

   AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:PINS] == '0); // R5
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_we) |=> $stable(bus_rdata)); // R9
endmodule

// File: tb/pin_bank_regs_bench.sv
module pin_bank_regs_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out;
   logic [31:0] pad_oe;

   int checks = 0;
   int errors = 0;
   logic [7:0] m_reg [3][4];
   logic [31:0] m_pad;

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_bank_regs u_pin_bank_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] merge(input logic [7:0] cur, input logic [15:0] wd);
      return (cur & ~wd[15:8]) | (wd[7:0] & wd[15:8]);
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      int kind = int'(a[5:4]);
      int port = int'(a[3:2]);
      if (a[6]) return 32'h0;
      if (kind == 3) return a[7] ? 32'h0 : {24'h0, m_pad[port*8 +: 8]};
      return {24'h0, m_reg[kind][port]};
   endfunction

   function automatic void model_write(input logic [7:0] a, input logic [31:0] wd);
      int kind = int'(a[5:4]);
      int port = int'(a[3:2]);
      if (a[6] || kind == 3) return;
      if (a[7]) m_reg[kind][port] = merge(m_reg[kind][port], wd[15:0]);
      else      m_reg[kind][port] = wd[7:0];
   endfunction

   function automatic logic [31:0] exp_oe();
      logic [31:0] v;
      for (int p = 0; p < 4; p++) v[p*8 +: 8] = m_reg[0][p] & m_reg[1][p];
      return v;
   endfunction

   function automatic logic [31:0] exp_out();
      logic [31:0] v;
      for (int p = 0; p < 4; p++) v[p*8 +: 8] = m_reg[2][p];
      return v;
   endfunction

   // called at a falling edge; returns at the next falling edge
   task automatic bus_write(input logic [7:0] a, input logic [31:0] wd);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = wd;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      model_write(a, wd);
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] rd);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      rd = bus_rdata;
   endtask

   task automatic read_chk(input string req, input logic [7:0] a);
      logic [31:0] rd;
      bus_read(a, rd);
      chk(req, rd, exp_read(a));
   endtask

   task automatic pads_chk(input string req);
      chk({req, " pad_out"}, pad_out, exp_out());
      chk({req, " pad_oe"}, pad_oe, exp_oe());
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'h1bad5eed));
      for (int k = 0; k < 3; k++) for (int p = 0; p < 4; p++) m_reg[k][p] = '0;
      m_pad = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      pads_chk("R1");
      for (int a = 0; a < 64; a += 4) read_chk("R1 reset read", 8'(a));

      // R2 R8 R10 port 2 set up, other ports untouched
      bus_write(8'h08, 32'hFF);
      bus_write(8'h18, 32'h0F);
      bus_write(8'h28, 32'hA5);
      chk("R10 port2 pad_out", {24'h0, pad_out[23:16]}, 32'hA5);
      chk("R8 port2 pad_oe", {24'h0, pad_oe[23:16]}, 32'h0F);
      pads_chk("R2");
      bus_write(8'h08, 32'h00);
      chk("R8 mode off gates oe", pad_oe, 32'h0);
      pads_chk("R8");

      // R3 plain write replaces
      bus_write(8'h28, 32'hFFFF_FF3C);
      read_chk("R3 plain write", 8'h28);

      // R4 masked writes
      bus_write(8'hA8, 32'h0000_0F05);
      chk("R4 masked merge", {24'h0, pad_out[23:16]}, 32'h35);
      bus_write(8'hA8, 32'h0000_00FF);
      chk("R4 empty mask", {24'h0, pad_out[23:16]}, 32'h35);
      bus_write(8'hA8, 32'h0000_8080);
      chk("R4 top pin", {24'h0, pad_out[23:16]}, 32'hB5);

      // R5 alias read
      read_chk("R5 alias read", 8'hA8);
      read_chk("R5 alias mode read", 8'h88);

      // R6 input read-only, R7 timing
      pad_in = 32'h5A3C_96E1; m_pad = 32'h0;
      read_chk("R7 edge1 old", 8'h34);
      read_chk("R7 edge2 old", 8'h34);
      m_pad = pad_in;
      read_chk("R7 edge3 new", 8'h34);
      for (int p = 0; p < 4; p++) read_chk("R6 input value", 8'(8'h30 + 4*p));
      bus_write(8'h34, 32'hFFFF_FFFF);
      bus_write(8'hB4, 32'hFFFF_FFFF);
      read_chk("R6 write ignored", 8'h34);
      pads_chk("R6");
      for (int a = 0; a < 48; a += 4) read_chk("R6 regs intact", 8'(a));

      // R9 unmapped
      bus_write(8'h40, 32'hFFFF);
      bus_write(8'h68, 32'hFFFF);
      read_chk("R9 unmapped read", 8'h68);
      read_chk("R9 alias input read", 8'hB0);
      pads_chk("R9");
      bus_read(8'h28, rd);
      repeat (3) @(negedge clk);
      chk("R9 read data holds", bus_rdata, exp_read(8'h28));

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [7:0] a;
         a = {1'($urandom), 1'($urandom % 8 == 0), 2'($urandom), 2'($urandom), 2'b00};
         if ($urandom % 3 == 0) begin
            read_chk("R2 R5 random read", a);
         end else begin
            bus_write(a, {16'($urandom), 16'($urandom)});
            pads_chk("R4 R8 random write");
         end
         if (i % 100 == 99) begin
            pad_in = $urandom;
            repeat (3) @(negedge clk);
            m_pad = pad_in;
         end
      end
      for (int a = 0; a < 256; a += 4) read_chk("R5 R9 final sweep", 8'(a));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule